// File: doc/BRIEF.md
# Presettable Cascadable BCD Up/Down Decade Counter

The block is one decimal digit of a counter. It holds a 4-bit BCD value and, on each rising clock edge, steps that value up or down by one when its active-low count enable is low. An active-high clear and an active-high parallel load act at once, with no wait for a clock. Clear takes priority over load, and load takes priority over counting. An active-low terminal-count output lets several digits share one clock and count as one multi-digit number. Each digit's enable input is tied to the terminal-count output of the digit below it.

The stored digit works as a small state machine. Its legal states are S0 to S9. Its transient states T10 to T15 can be reached only through a parallel load. The control inputs choose one of five actions: CLEAR, LOAD, HOLD, UP and DOWN. Under UP, the transitions are Sk to Sk+1 for k below 9 and S9 to S0 (wrap). Under DOWN, they are Sk to Sk-1 for k above 0 and S0 to S9 (wrap). The transient states lead back into the legal range. Under UP: T10 to T11 to S0, T12 to T13 to S0, and T14 to T15 to S0. Under DOWN: T15 to T14 to T13 to T12 to S9, and T11 to T10 to S9. CLEAR goes to S0 from any state. LOAD goes to the state given by the load bus. HOLD keeps the current state.

Top module: `bcd_updown_decade`

## Requirements
- R1: While `clr` is high, `count` is 0 at once, with no clock edge needed and whatever the other inputs are.
- R2: While `clr` is low and `load` is high, `count` equals `load_val` at once, with no clock edge needed. Every rising clock edge during that time reloads the digit. After `load` falls, the value loaded last is kept.
- R3: When `clr` and `load` are low and `en_n` is high, a rising clock edge leaves `count` unchanged.
- R4: When `clr` and `load` are low, `en_n` is low and `up` is 1, each rising edge adds one to `count`. The value 9 wraps to 0.
- R5: When `clr` and `load` are low, `en_n` is low and `up` is 0, each rising edge subtracts one from `count`. The value 0 wraps to 9.
- R6: Counting up from a non-BCD value gives these next values: 10 to 11, 11 to 0, 12 to 13, 13 to 0, 14 to 15, 15 to 0. The count is therefore legal within 2 clocks.
- R7: Counting down from a non-BCD value gives these next values: 15 to 14, 14 to 13, 13 to 12, 12 to 9, 11 to 10, 10 to 9. The count is therefore legal within 4 clocks.
- R8: `tc_n` is low exactly when `en_n` is low and `count` is 9 with `up`=1, or `count` is 0 with `up`=0. It is combinational, so it follows `en_n` with no clock edge. It is never low for a value from 10 to 15.
- R9: When two digits share `clk` and the upper digit's `en_n` is driven by the lower digit's `tc_n`, the pair counts as one two-digit decimal number in both directions, including 99 to 00 and 00 to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clr | input | 1 | Asynchronous clear to 0, highest priority |
| load | input | 1 | Asynchronous parallel load, active high |
| load_val | input | 4 | Value taken by a load |
| en_n | input | 1 | Count enable, active low; connects to the lower digit's `tc_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | 4 | Current BCD digit |
| tc_n | output | 1 | Terminal count for the next digit, active low |

## Verification
A wrong next-state entry appears on `count` one clock after the affected value is entered. A slip in wrap or non-BCD recovery therefore appears within one edge. In a two-digit chain, the wrong value also moves the upper digit on the same edge. A fault in the terminal-count decode appears on `tc_n` with no clock at all, as soon as `en_n` or `up` changes at 9 or 0. Errors in clear or load priority appear on `count` within a time step, without any clock edge.

// File: rtl/bcd_decade_pkg.sv
package bcd_decade_pkg;
    localparam int DIG_W = 4;
    typedef logic [DIG_W-1:0] digit_t;
    localparam digit_t DIG_TOP = digit_t'(9);

    typedef enum logic [2:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN
    } act_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_decade_pkg::*;
(
    input  digit_t cur,
    input  logic   go_up,
    output digit_t nxt
);
    always_comb begin
        if (go_up) begin
            if (cur < DIG_TOP)       nxt = cur + digit_t'(1);
            else if (cur == DIG_TOP) nxt = '0;
            else if (cur[0])         nxt = '0;              // odd transient states close to zero
            else                     nxt = cur + digit_t'(1); // even transient states step once
        end else begin
            if (cur == '0)           nxt = DIG_TOP;
            else if (cur <= DIG_TOP) nxt = cur - digit_t'(1);
            else if (cur == digit_t'(12) || cur == digit_t'(10)) nxt = DIG_TOP;
            else                     nxt = cur - digit_t'(1);
        end
    end
endmodule

// File: rtl/bcd_carry_term.sv
module bcd_carry_term
    import bcd_decade_pkg::*;
(
    input  digit_t val,
    input  logic   cin_n,
    input  logic   go_up,
    output logic   cout_n
);
    logic at_end;

    always_comb begin
        at_end = go_up ? (val == DIG_TOP) : (val == '0);
        cout_n = ~(~cin_n & at_end);
    end
endmodule

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade
    import bcd_decade_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       load,
    input  logic [3:0] load_val,
    input  logic       en_n,
    input  logic       up,
    output logic [3:0] count,
    output logic       tc_n
);
    act_e   act;
    digit_t state_q;
    digit_t step_nxt;

    // action decode, fixed priority
    always_comb begin
        if (clr)        act = ACT_CLEAR;
        else if (load)  act = ACT_LOAD;
        else if (en_n)  act = ACT_HOLD;
        else if (up)    act = ACT_UP;
        else            act = ACT_DOWN;
    end

    bcd_step u_step (
        .cur   (state_q),
        .go_up (up),
        .nxt   (step_nxt)
    );

    // state register
    always_ff @(posedge clk or posedge clr or posedge load) begin
        if (clr)        state_q <= '0;
        else if (load)  state_q <= load_val;
        else if (!en_n) state_q <= step_nxt;
    end

    // outputs: transparent while clear or load is held
    always_comb begin
        unique case (act)
            ACT_CLEAR: count = '0;
            ACT_LOAD:  count = load_val;
            default:   count = state_q;
        endcase
    end

    bcd_carry_term u_carry (
        .val    (count),
        .cin_n  (en_n),
        .go_up  (up),
        .cout_n (tc_n)
    );

    a_r3_hold: assert property (@(posedge clk) disable iff (clr || load)
        en_n |=> $stable(count));

    a_r4_step_up: assert property (@(posedge clk) disable iff (clr || load)
        (!en_n && up && count < 4'd9) |=> (count == $past(count) + 4'd1));

    a_r5_step_down: assert property (@(posedge clk) disable iff (clr || load)
        (!en_n && !up && count != 4'd0 && count <= 4'd9) |=> (count == $past(count) - 4'd1));

    a_r6_odd_to_zero: assert property (@(posedge clk) disable iff (clr || load)
        (!en_n && up && count > 4'd9 && count[0]) |=> (count == 4'd0));

    a_r7_down_lands_nine: assert property (@(posedge clk) disable iff (clr || load)
        (!en_n && !up && (count == 4'd10 || count == 4'd12)) |=> (count == 4'd9));

    a_r8_tc_legal: assert property (@(posedge clk) disable iff (clr)
        !tc_n |-> (!en_n && (count == 4'd9 || count == 4'd0)));

    always_comb begin
        if (clr) a_r1_clear_now: assert (count == 4'd0);
    end
endmodule

// File: tb/test_bcd_updown_decade.sv
module test_bcd_updown_decade;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       clr, load, en_n, up;
    logic [3:0] load_val, load_val_hi;
    logic [3:0] count, count_hi;
    logic       tc_n, tc_n_hi;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    bcd_updown_decade i_bcd_updown_decade (
        .clk(clk), .clr(clr), .load(load), .load_val(load_val),
        .en_n(en_n), .up(up), .count(count), .tc_n(tc_n)
    );

    bcd_updown_decade i_bcd_updown_decade_hi (
        .clk(clk), .clr(clr), .load(load), .load_val(load_val_hi),
        .en_n(tc_n), .up(up), .count(count_hi), .tc_n(tc_n_hi)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [3:0] v);
        load_val = v;
        load = 1'b1;
        tick();
        load = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        load_val = 4'd6; load = 1'b1; clr = 1'b1; en_n = 1'b0; up = 1'b1;
        #1 chk("R1 clear beats load", count, 4'd0);
        tick();
        chk("R1 clear held over edge", count, 4'd0);
        clr = 1'b0; load = 1'b0;
        tick();
        en_n = 1'b1;
    endtask

    task automatic t_load();
        @(negedge clk);
        en_n = 1'b0;
        load_val = 4'd7;
        #2 load = 1'b1;
        #1 chk("R2 load without clock", count, 4'd7);
        tick();
        load_val = 4'd3;
        tick();
        load = 1'b0;
        #1 chk("R2 last load kept", count, 4'd3);
        en_n = 1'b1;
    endtask

    task automatic t_hold();
        put(4'd5);
        en_n = 1'b1; up = 1'b1;
        tick(); tick();
        chk("R3 hold", count, 4'd5);
    endtask

    task automatic t_up();
        put(4'd0);
        en_n = 1'b0; up = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            tick();
            chk("R4 count up", count, 4'(k % 10));
        end
        en_n = 1'b1;
    endtask

    task automatic t_down();
        put(4'd2);
        en_n = 1'b0; up = 1'b0;
        tick(); chk("R5 count down", count, 4'd1);
        tick(); chk("R5 count down", count, 4'd0);
        tick(); chk("R5 wrap 0 to 9", count, 4'd9);
        tick(); chk("R5 count down", count, 4'd8);
        en_n = 1'b1;
    endtask

    task automatic t_bad_up();
        logic [3:0] exp_up [6] = '{4'd11, 4'd0, 4'd13, 4'd0, 4'd15, 4'd0};
        for (int v = 10; v <= 15; v++) begin
            put(4'(v));
            en_n = 1'b0; up = 1'b1;
            chk("R8 no carry on illegal", {3'd0, tc_n}, 4'd1);
            tick();
            chk("R6 illegal up step", count, exp_up[v-10]);
            tick();
            total++;
            if (count > 4'd9) begin
                bad++;
                $display("FAIL R6 not legal after 2 clocks: got %0d expected <=9", count);
            end
            en_n = 1'b1;
        end
    endtask

    task automatic t_bad_down();
        logic [3:0] exp_dn [6] = '{4'd9, 4'd10, 4'd9, 4'd12, 4'd13, 4'd14};
        for (int v = 10; v <= 15; v++) begin
            put(4'(v));
            en_n = 1'b0; up = 1'b0;
            tick();
            chk("R7 illegal down step", count, exp_dn[v-10]);
            en_n = 1'b1;
        end
        put(4'd15);
        en_n = 1'b0; up = 1'b0;
        tick(); tick(); tick(); tick();
        chk("R7 15 legal after 4 clocks", count, 4'd9);
        en_n = 1'b1;
    endtask

    task automatic t_carry();
        put(4'd9);
        en_n = 1'b0; up = 1'b1;
        #1 chk("R8 tc at 9 up", {3'd0, tc_n}, 4'd0);
        en_n = 1'b1;
        #1 chk("R8 tc follows enable", {3'd0, tc_n}, 4'd1);
        en_n = 1'b0; up = 1'b0;
        #1 chk("R8 no tc at 9 down", {3'd0, tc_n}, 4'd1);
        en_n = 1'b1;
        put(4'd0);
        en_n = 1'b0; up = 1'b0;
        #1 chk("R8 tc at 0 down", {3'd0, tc_n}, 4'd0);
        up = 1'b1;
        #1 chk("R8 no tc at 0 up", {3'd0, tc_n}, 4'd1);
        en_n = 1'b1;
    endtask

    task automatic t_cascade();
        en_n = 1'b1;
        load_val_hi = 4'd9;
        put(4'd8);
        en_n = 1'b0; up = 1'b1;
        tick();
        chk("R9 low digit 99", count, 4'd9);
        chk("R9 high digit 99", count_hi, 4'd9);
        #1 chk("R9 high tc at 99", {3'd0, tc_n_hi}, 4'd0);
        tick();
        chk("R9 low digit 00", count, 4'd0);
        chk("R9 high digit 00", count_hi, 4'd0);
        up = 1'b0;
        tick();
        chk("R9 low digit back to 99", count, 4'd9);
        chk("R9 high digit back to 99", count_hi, 4'd9);
        tick();
        chk("R9 low digit 98", count, 4'd8);
        chk("R9 high digit stays 9", count_hi, 4'd9);
        en_n = 1'b1;
    endtask

    initial begin
        clr = 1'b1; load = 1'b0; en_n = 1'b1; up = 1'b1;
        load_val = '0; load_val_hi = '0;
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_bad_up();
        t_bad_down();
        t_carry();
        t_cascade();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule